// File: doc/BRIEF.md
# Serial Boot ROM Loader

After power-on self-test, this block copies a fixed-length bit stream from an external serial ROM into an on-chip destination. The destination is modelled as a parallel word-write port. The loader divides the fast core clock down to make the serial ROM clock. While the transfer runs it holds the ROM's active-low output enable low. It samples the ROM data line once per serial clock period, at a fixed core-cycle offset after the rising edge.

Bits are gathered most-significant first into words. Each completed word produces one write strobe, and the write address starts at zero and increases by one per word. When the last word has been written, the loader gives the reset sequencer a one-cycle done pulse, so the sequencer can release the internal reset. If the ROM-present strap reads "absent" when the start request arrives, no transfer takes place and done follows at once.

Only one load runs per reset. The serial clock period is `BASE_PERIOD - CLK_RATIO` core cycles. The sample point is core cycle `BASE_PERIOD - 5*CLK_RATIO - 1` of each period, counting the rising-edge cycle as cycle 0. This is the latest cycle that still meets the setup window allowed for the ROM's clock-to-data delay.

Top module: `srl_boot_loader`

## Requirements
- R1: A load begins only in a cycle where `bist_done_i` is 1 and `rom_present_ni` is 0 (the strap is active low) while the loader is idle. With `bist_done_i` held at 0, `rom_oe_no` stays 1 and no write occurs.
- R2: If `rom_present_ni` is 1 when `bist_done_i` is seen, `rom_oe_no` never goes low, no write occurs, and `load_done_o` is 1 in the cycle after the start request was sampled.
- R3: `rom_oe_no` is 0 from the cycle after the start request is accepted up to, but not including, the cycle in which `load_done_o` is 1. It is 1 at all other times. `rom_clk_o` is high only while `rom_oe_no` is 0.
- R4: During a load, `rom_clk_o` has a period of `BASE_PERIOD - CLK_RATIO` core cycles and is high for the first `(BASE_PERIOD - CLK_RATIO)/2` of them. Its first rising edge comes in the first cycle of the load.
- R5: `rom_data_i` is captured at the end of core cycle `BASE_PERIOD - 5*CLK_RATIO - 1` of each serial period, where cycle 0 is the cycle in which `rom_clk_o` rises. The value at any other cycle has no effect.
- R6: Exactly `NUM_BITS` bits are read. The first bit received becomes bit `WORD_W-1` of word 0, and each word is written once. Addresses run 0, 1, … `NUM_BITS/WORD_W - 1` in order.
- R7: `wr_en_o` is 1 for exactly one cycle, the cycle right after the sample that completes a word. `wr_data_o` and `wr_addr_o` are valid in that cycle.
- R8: `load_done_o` is a one-cycle pulse in the cycle right after the final word write, and `rom_oe_no` returns to 1 in that same cycle.
- R9: After `load_done_o`, further start requests are ignored until reset: `rom_oe_no` stays 1, and neither a write nor another done occurs.
- R10: While reset is asserted, `rom_oe_no` is 1 and `rom_clk_o`, `wr_en_o` and `load_done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bist_done_i | input | 1 | Start request: self-test has finished |
| rom_present_ni | input | 1 | Strap, 0 when a serial ROM is fitted |
| rom_data_i | input | 1 | Serial data from the ROM |
| rom_clk_o | output | 1 | Serial clock to the ROM |
| rom_oe_no | output | 1 | Active-low ROM output enable |
| wr_en_o | output | 1 | Word write strobe |
| wr_addr_o | output | ADDR_W | Word address, counting up from 0 |
| wr_data_o | output | WORD_W | Assembled word, first bit received in the MSB |
| load_done_o | output | 1 | One-cycle pulse when the load is complete |

## Verification
The embedded assertions check, on every cycle, a set of relationships that hold throughout. Write and done strobes are one cycle wide. A write always follows a sample. Addresses step by one. The serial clock only runs while the enable is low. The enable only falls after an accepted start with the ROM present, and only rises together with done. Once done, the controller never leaves its final state.

Other properties only the bench scenarios can show. These are that the serial clock has the right period and duty cycle, and that data is taken at exactly the stated cycle; the bench's ROM model drives the correct bit in that cycle alone. The bench also shows the MSB-first word assembly and the exact cycles of the enable, the writes and done, including the case where no ROM is fitted and the case of a repeated start.

// File: rtl/srl_pkg.sv
package srl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_DONE = 2'd2,
    ST_HALT = 2'd3
  } srl_state_e;

  function automatic int unsigned srl_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/srl_sclk_gen.sv
module srl_sclk_gen #(
  parameter int unsigned PERIOD    = 123,
  parameter int unsigned HIGH_CYC  = 61,
  parameter int unsigned SAMPLE_PT = 110
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic sample_o
);
  import srl_pkg::*;

  localparam int unsigned PH_W = srl_width(PERIOD);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(HIGH_CYC);
  localparam logic [PH_W-1:0] PH_SMP  = PH_W'(SAMPLE_PT);

  logic [PH_W-1:0] phase_q, phase_d;
  logic            phase_en;

  assign phase_en = run_i || (phase_q != '0);

  always_comb begin
    phase_d = phase_q;
    if (!run_i) begin
      phase_d = '0;
    end else if (phase_q == PH_LAST) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end

  assign sclk_o   = run_i && (phase_q < PH_HIGH);
  assign sample_o = run_i && (phase_q == PH_SMP);

  // R4: the serial clock starts high in the first cycle of a load
  a_r4_first_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> sclk_o);

  // R5: one sample per period, never on consecutive cycles
  a_r5_sample_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);

endmodule

// File: rtl/srl_deser.sv
module srl_deser #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 3200,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              bit_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              wr_last_o
);
  import srl_pkg::*;

  localparam int unsigned BP_W = srl_width(WORD_W);
  localparam logic [BP_W-1:0]   BP_LAST = BP_W'(WORD_W - 1);
  localparam logic [ADDR_W-1:0] WD_LAST = ADDR_W'(NUM_WORDS - 1);

  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [BP_W-1:0]   bitpos_q, bitpos_d;
  logic [ADDR_W-1:0] widx_q, widx_d;
  logic              wr_en_q, wr_en_d;
  logic [ADDR_W-1:0] wr_addr_q, wr_addr_d;
  logic [WORD_W-1:0] wr_data_q, wr_data_d;
  logic              wr_last_q, wr_last_d;
  logic              word_full;

  assign word_full = sample_i && (bitpos_q == BP_LAST);

  always_comb begin
    shreg_d   = shreg_q;
    bitpos_d  = bitpos_q;
    widx_d    = widx_q;
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr_q;
    wr_data_d = wr_data_q;
    wr_last_d = 1'b0;
    if (sample_i) begin
      shreg_d  = {shreg_q[WORD_W-2:0], bit_i};
      bitpos_d = word_full ? '0 : bitpos_q + 1'b1;
    end
    if (word_full) begin
      wr_en_d   = 1'b1;
      wr_addr_d = widx_q;
      wr_data_d = {shreg_q[WORD_W-2:0], bit_i};
      wr_last_d = (widx_q == WD_LAST);
      widx_d    = widx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q  <= '0;
      bitpos_q <= '0;
      widx_q   <= '0;
    end else if (sample_i) begin
      shreg_q  <= shreg_d;
      bitpos_q <= bitpos_d;
      widx_q   <= widx_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q   <= 1'b0;
      wr_last_q <= 1'b0;
    end else begin
      wr_en_q   <= wr_en_d;
      wr_last_q <= wr_last_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (word_full) begin
      wr_addr_q <= wr_addr_d;
      wr_data_q <= wr_data_d;
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign wr_last_o = wr_last_q;

  // checker-side history of the previous write address
  logic [ADDR_W-1:0] chk_prev_addr_q;
  logic              chk_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_prev_addr_q <= '0;
      chk_seen_q      <= 1'b0;
    end else if (wr_en_o) begin
      chk_prev_addr_q <= wr_addr_o;
      chk_seen_q      <= 1'b1;
    end
  end

  // R6: first write to address 0, each later write one address higher
  a_r6_first_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !chk_seen_q) |-> (wr_addr_o == '0));
  a_r6_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && chk_seen_q) |-> (wr_addr_o == chk_prev_addr_q + 1'b1));

  // R7: a write strobe is one cycle wide and directly follows a sample
  a_r7_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  a_r7_wr_after_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> $past(sample_i));

endmodule

// File: rtl/srl_seq.sv
module srl_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic present_ni,
  input  logic last_wr_i,
  output logic load_o,
  output logic done_o
);
  import srl_pkg::*;

  srl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = present_ni ? ST_DONE : ST_LOAD;
      ST_LOAD: if (last_wr_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_HALT;
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign load_o = (state_q == ST_LOAD);
  assign done_o = (state_q == ST_DONE);

  // R1: a load only follows an accepted start with the ROM present
  a_r1_start_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_o) |-> ($past(start_i) && !$past(present_ni)));

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9: after done the controller never leaves its final state
  a_r9_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT) |=> (state_q == ST_HALT));

endmodule

// File: rtl/srl_boot_loader.sv
module srl_boot_loader #(
  parameter int unsigned NUM_BITS    = 102400,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned BASE_PERIOD = 126,
  parameter int unsigned CLK_RATIO   = 3,
  localparam int unsigned NUM_WORDS  = NUM_BITS / WORD_W,
  localparam int unsigned ADDR_W     = srl_pkg::srl_width(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bist_done_i,
  input  logic              rom_present_ni,
  input  logic              rom_data_i,
  output logic              rom_clk_o,
  output logic              rom_oe_no,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              load_done_o
);

  localparam int unsigned PERIOD    = BASE_PERIOD - CLK_RATIO;
  localparam int unsigned HIGH_CYC  = PERIOD / 2;
  localparam int unsigned SAMPLE_PT = BASE_PERIOD - 5 * CLK_RATIO - 1;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  logic load;
  logic sample;
  logic wr_en;
  logic wr_last;

  srl_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .start_i    (bist_done_i),
    .present_ni (rom_present_ni),
    .last_wr_i  (wr_en && wr_last),
    .load_o     (load),
    .done_o     (load_done_o)
  );

  srl_sclk_gen #(
    .PERIOD    (PERIOD),
    .HIGH_CYC  (HIGH_CYC),
    .SAMPLE_PT (SAMPLE_PT)
  ) u_sclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .run_i    (load),
    .sclk_o   (rom_clk_o),
    .sample_o (sample)
  );

  srl_deser #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W)
  ) u_deser (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .sample_i  (sample),
    .bit_i     (rom_data_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .wr_last_o (wr_last)
  );

  assign wr_en_o   = wr_en;
  assign rom_oe_no = !load;

  // R3: serial clock pulses only while the ROM is enabled
  a_r3_clk_needs_oe: assert property (@(posedge clk_i) disable iff (!rst_n)
    rom_clk_o |-> !rom_oe_no);

  // R8: the enable is released together with done
  a_r8_oe_release: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rom_oe_no) |-> load_done_o);

  // R2: writes happen only while the ROM is enabled
  a_r2_wr_needs_oe: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_en_o |-> !rom_oe_no);

endmodule

// File: tb/srl_boot_loader_tb.sv
`timescale 1ns/1ps
module srl_boot_loader_tb;

  localparam int NB   = 128;
  localparam int WW   = 32;
  localparam int BASE = 20;
  localparam int RAT  = 2;
  localparam int PER  = BASE - RAT;
  localparam int HI   = PER / 2;
  localparam int SPT  = BASE - 5 * RAT - 1;
  localparam int NW   = NB / WW;
  localparam int AW   = 2;

  // stimulus words held by the ROM model and the expected write results
  localparam logic [WW-1:0] WORDS [NW] = '{
    32'hA5C3_0F96, 32'h0000_0001, 32'h8000_0000, 32'h1234_ABCD
  };

  logic clk = 1'b0;
  logic rst_n;
  logic bist_done, present_n, rom_data;
  logic rom_clk, rom_oe_n, wr_en, done;
  logic [AW-1:0] wr_addr;
  logic [WW-1:0] wr_data;

  always #2.5 clk = ~clk;

  srl_boot_loader #(
    .NUM_BITS    (NB),
    .WORD_W      (WW),
    .BASE_PERIOD (BASE),
    .CLK_RATIO   (RAT)
  ) u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .bist_done_i    (bist_done),
    .rom_present_ni (present_n),
    .rom_data_i     (rom_data),
    .rom_clk_o      (rom_clk),
    .rom_oe_no      (rom_oe_n),
    .wr_en_o        (wr_en),
    .wr_addr_o      (wr_addr),
    .wr_data_o      (wr_data),
    .load_done_o    (done)
  );

  int n_checks = 0;
  int n_errors = 0;

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor and ROM model, all at the falling edge
  int cyc = 0;
  int k = 0;
  int bidx = -1;
  logic prev_clk = 1'b0;
  int n_rise, rise_cyc [4], hi_cnt;
  int n_samp, last_samp_cyc;
  int n_wr, wr_timing_bad;
  logic [AW-1:0] got_addr [NW];
  logic [WW-1:0] got_data [NW];
  int n_done, done_cyc, done_oe, last_wr_cyc;
  int n_oe_low, first_oe_cyc;
  logic prev_wr = 1'b0;

  task automatic mon_clear();
    n_rise = 0; hi_cnt = 0; n_samp = 0; last_samp_cyc = -10;
    n_wr = 0; wr_timing_bad = 0; n_done = 0; done_cyc = -1; done_oe = -1;
    last_wr_cyc = -1; n_oe_low = 0; first_oe_cyc = -1; bidx = -1; k = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rom_clk && !prev_clk) begin
      k = 0;
      bidx++;
      if (n_rise < 4) rise_cyc[n_rise] = cyc;
      n_rise++;
    end else begin
      k++;
    end
    prev_clk = rom_clk;
    if (rom_clk && n_rise == 1) hi_cnt++;
    if (!rom_oe_n) begin
      if (first_oe_cyc < 0) first_oe_cyc = cyc;
      n_oe_low++;
    end
    if (bidx >= 0 && bidx < NB) begin
      logic b;
      b = WORDS[bidx / WW][WW - 1 - (bidx % WW)];
      rom_data = (k == SPT) ? b : ~b;
      if (k == SPT && !rom_oe_n) begin
        n_samp++;
        last_samp_cyc = cyc;
      end
    end else begin
      rom_data = 1'b0;
    end
    if (wr_en) begin
      if (n_wr < NW) begin
        got_addr[n_wr] = wr_addr;
        got_data[n_wr] = wr_data;
      end
      if (cyc != last_samp_cyc + 1 || (n_samp % WW) != 0 || prev_wr) wr_timing_bad++;
      last_wr_cyc = cyc;
      n_wr++;
    end
    prev_wr = wr_en;
    if (done) begin
      n_done++;
      done_cyc = cyc;
      done_oe = rom_oe_n;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic do_reset(input logic pres_n);
    rst_n = 1'b0; bist_done = 1'b0; present_n = pres_n;
    tick(3);
    check("R10 oe_n in reset", rom_oe_n === 1'b1, rom_oe_n, 1);
    check("R10 rom_clk in reset", rom_clk === 1'b0, rom_clk, 0);
    check("R10 wr_en in reset", wr_en === 1'b0, wr_en, 0);
    check("R10 done in reset", done === 1'b0, done, 0);
    rst_n = 1'b1;
    tick(4);
    mon_clear();
  endtask

  int start_cyc;

  task automatic pulse_start();
    bist_done = 1'b1;
    start_cyc = cyc;
    tick(1);
    bist_done = 1'b0;
  endtask

  initial begin
    rom_data = 1'b0;
    mon_clear();
    do_reset(1'b0);

    // R1: no start request, nothing happens
    tick(40);
    check("R1 oe idle without start", n_oe_low == 0, n_oe_low, 0);
    check("R1 no write without start", n_wr == 0 && n_done == 0, n_wr, 0);

    // full load
    mon_clear();
    pulse_start();
    begin
      int t = 0;
      while (n_done == 0 && t < 20000) begin
        tick(1);
        t++;
      end
      if (n_done == 0) check("R8 load completes", 1'b0, 0, 1);
    end
    tick(2);

    check("R3 oe falls cycle after start", first_oe_cyc == start_cyc + 1, first_oe_cyc, start_cyc + 1);
    check("R4 first rise at load start", rise_cyc[0] == start_cyc + 1, rise_cyc[0], start_cyc + 1);
    check("R4 period", rise_cyc[1] - rise_cyc[0] == PER && rise_cyc[2] - rise_cyc[1] == PER,
          rise_cyc[1] - rise_cyc[0], PER);
    check("R4 high time", hi_cnt == HI, hi_cnt, HI);
    check("R6 bits read", n_samp == NB, n_samp, NB);
    check("R6 word count", n_wr == NW, n_wr, NW);
    // walk the vector table: R5 sample point and R6 MSB-first order and addresses
    for (int w = 0; w < NW; w++) begin
      check("R6 write address", got_addr[w] == AW'(w), got_addr[w], w);
      check("R5 R6 write data", got_data[w] == WORDS[w], got_data[w], WORDS[w]);
    end
    check("R7 write timing", wr_timing_bad == 0, wr_timing_bad, 0);
    check("R8 single done", n_done == 1, n_done, 1);
    check("R8 done after last write", done_cyc == last_wr_cyc + 1, done_cyc, last_wr_cyc + 1);
    check("R8 oe released with done", done_oe == 1, done_oe, 1);
    check("R3 oe low span", n_oe_low == done_cyc - (start_cyc + 1), n_oe_low, done_cyc - (start_cyc + 1));

    // R9: second start ignored
    mon_clear();
    pulse_start();
    tick(3 * PER);
    check("R9 restart ignored oe", n_oe_low == 0, n_oe_low, 0);
    check("R9 restart ignored done/wr", n_done == 0 && n_wr == 0, n_done + n_wr, 0);

    // R2: no ROM fitted
    do_reset(1'b1);
    pulse_start();
    tick(3 * PER);
    check("R2 done cycle after start", n_done == 1 && done_cyc == start_cyc + 1, done_cyc, start_cyc + 1);
    check("R2 oe never low", n_oe_low == 0, n_oe_low, 0);
    check("R2 no writes", n_wr == 0, n_wr, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule